// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block lets an on-chip core reach byte-wide external memory over a bus on which the low address byte and the data byte share one set of pins. The core presents a 16-bit address, a write flag, write data, a flag that selects program space or data space, and a one-clock start pulse. The block then steps the bus through five phases. First it drives the address. Next it pulses the address strobe while the low byte is on the shared lines. It then releases those lines, pulses the data strobe, and finally holds the bus for recovery. At the end it returns one clock of done together with any read data.

During each transaction the block also drives the read/write level, the program-space and data-space selects, and separate read and write strobes. It drives the enable for the shared lines' tristate driver. Slow devices can stretch the data strobe in two ways. A fixed count of automatic wait clocks can be chosen per request, and an active-low wait input can add further clocks. An extended timing mode widens the address strobe, the float gap, the data strobe and the recovery time.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset and while idle, as_n_o, ds_n_o, mr_n_o, mw_n_o, pm_n_o and dm_n_o are high, and ad_oe_o, wr_o and done_o are low.
- R2: An accepted request starts with one address clock. In that clock ad_oe_o is high, ad_o carries address bits 7:0 and addr_hi_o carries bits 15:8. The next phase drives as_n_o low for 1 clock in normal mode, and the same address stays driven throughout that phase.
- R3: wr_o (1 = write, 0 = read) equals the request's write flag from the address clock through the last recovery clock, so it is valid before as_n_o falls. It does not change while ds_n_o stays low.
- R4: On a read, ad_oe_o is low from the rise of as_n_o until the end of recovery. The gap with both strobes high lasts 1 clock in normal mode. ds_n_o and as_n_o are never low together.
- R5: On a write, ad_o carries the write data with ad_oe_o high in the one setup clock before ds_n_o falls, in every clock of the data strobe, and in the first clock after ds_n_o rises.
- R6: With no wait clocks and normal timing, ds_n_o stays low for 4 clocks on a read and 2 clocks on a write.
- R7: On a read, ad_i is sampled at the clock edge at which ds_n_o returns high. That byte is on rdata_o when done_o is high.
- R8: When req_prog_i is 1, pm_n_o is low and dm_n_o is high from the address clock to the end of recovery; when it is 0 the roles swap. mr_n_o is low exactly during a read data strobe, and mw_n_o is low exactly during a write data strobe.
- R9: auto_wait_i (0 to 3) adds that many clocks to the data strobe whatever the level of wait_n_i.
- R10: wait_n_i is looked at only in the last scheduled data-strobe clock. Each clock in which it is low there adds one more strobe clock, and a low level in earlier clocks has no effect.
- R11: ext_mode_i = 1 adds 1 clock each to the address strobe, the float gap, the data strobe and recovery. done_o is high in the clock after the last recovery clock, so a transaction occupies 1 + strobe + gap + setup + data strobe + recovery clocks before it.
- R12: req_i is ignored while a transaction is in progress, and the mode and auto-wait inputs are captured only when a request is accepted. done_o is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start pulse, accepted when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_prog_i | input | 1 | 1 = program space, 0 = data space |
| req_addr_i | input | 16 | Transaction address |
| req_wdata_i | input | 8 | Write data |
| ext_mode_i | input | 1 | 1 = extended timing |
| auto_wait_i | input | 2 | Automatic wait clocks, 0 to 3 |
| wait_n_i | input | 1 | Active-low wait request from memory |
| ad_i | input | 8 | Shared lines as seen from the pads |
| addr_hi_o | output | 8 | Address bits 15:8 |
| ad_o | output | 8 | Value driven onto the shared lines |
| ad_oe_o | output | 1 | Tristate enable for the shared lines |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| wr_o | output | 1 | Read/write level, 1 = write |
| mr_n_o | output | 1 | Memory read strobe, active low |
| mw_n_o | output | 1 | Memory write strobe, active low |
| pm_n_o | output | 1 | Program space select, active low |
| dm_n_o | output | 1 | Data space select, active low |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench goes after four corner cases. The first is the wait input held low during the automatic wait clocks: a sequencer that samples it too early would stretch the strobe by too much. The second is a second request pulsed mid-transaction with the timing mode flipped: a design that accepts it would emit phantom strobes or an extra done, and one that does not latch the mode would mistime the remaining phases. The third is the shared lines on reads, which must float from the rise of the address strobe onward: a design that leaves the enable on would fight the memory. The fourth is write data around the data strobe, which needs one clock of setup and one of hold. Transactions at addresses 0x0000 and 0xFFFF, with mixed spaces, and in extended mode with the maximum automatic wait count, check the strobe widths and the total latency.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_ASTB  = 3'd2,
        ST_FLOAT = 3'd3,
        ST_DSET  = 3'd4,
        ST_DSTB  = 3'd5,
        ST_REC   = 3'd6
    } xbus_state_e;
endpackage

// File: rtl/xbus_phase_len.sv
// Phase lengths in clocks for the transaction that is running.
module xbus_phase_len #(
    parameter int AS_CLKS    = 1,
    parameter int GAP_CLKS   = 1,
    parameter int REC_CLKS   = 1,
    parameter int RD_DS_CLKS = 4,
    parameter int WR_DS_CLKS = 2,
    parameter int EXT_CLKS   = 1,
    parameter int AW_W       = 2,
    parameter int CNT_W      = 5
) (
    input  logic             ext_i,
    input  logic             wr_i,
    input  logic [AW_W-1:0]  auto_wait_i,
    output logic [CNT_W-1:0] as_len_o,
    output logic [CNT_W-1:0] gap_len_o,
    output logic [CNT_W-1:0] ds_len_o,
    output logic [CNT_W-1:0] rec_len_o
);
    logic [CNT_W-1:0] stretch;

    generate
        if (EXT_CLKS == 0) begin : g_no_ext
            assign stretch = '0;
        end else begin : g_ext
            assign stretch = ext_i ? CNT_W'(EXT_CLKS) : '0;
        end
    endgenerate

    assign as_len_o  = CNT_W'(AS_CLKS)  + stretch;
    assign gap_len_o = CNT_W'(GAP_CLKS) + stretch;
    assign rec_len_o = CNT_W'(REC_CLKS) + stretch;
    assign ds_len_o  = (wr_i ? CNT_W'(WR_DS_CLKS) : CNT_W'(RD_DS_CLKS))
                     + CNT_W'(auto_wait_i) + stretch;
endmodule

// File: rtl/xbus_space_dec.sv
// Space selects and the read/write strobes.
module xbus_space_dec (
    input  logic active_i,
    input  logic prog_i,
    input  logic wr_i,
    input  logic dstb_i,
    output logic pm_n_o,
    output logic dm_n_o,
    output logic mr_n_o,
    output logic mw_n_o
);
    assign pm_n_o = ~(active_i & prog_i);
    assign dm_n_o = ~(active_i & ~prog_i);
    assign mr_n_o = ~(dstb_i & ~wr_i);
    assign mw_n_o = ~(dstb_i & wr_i);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int AS_CLKS    = 1,
    parameter int GAP_CLKS   = 1,
    parameter int REC_CLKS   = 1,
    parameter int RD_DS_CLKS = 4,
    parameter int WR_DS_CLKS = 2,
    parameter int EXT_CLKS   = 1,
    parameter int AW_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic              req_prog_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              ext_mode_i,
    input  logic [AW_W-1:0]   auto_wait_i,
    input  logic              wait_n_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_o,
    output logic              as_n_o,
    output logic              ds_n_o,
    output logic              wr_o,
    output logic              mr_n_o,
    output logic              mw_n_o,
    output logic              pm_n_o,
    output logic              dm_n_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);
    localparam int MAX_LEN = AS_CLKS + GAP_CLKS + REC_CLKS + RD_DS_CLKS
                           + WR_DS_CLKS + EXT_CLKS + (1 << AW_W);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        xbus_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              prog;
        logic              ext;
        logic [AW_W-1:0]   autow;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t r_d, r_q;

    logic [CNT_W-1:0] as_len, gap_len, ds_len, rec_len;

    xbus_phase_len #(
        .AS_CLKS(AS_CLKS), .GAP_CLKS(GAP_CLKS), .REC_CLKS(REC_CLKS),
        .RD_DS_CLKS(RD_DS_CLKS), .WR_DS_CLKS(WR_DS_CLKS),
        .EXT_CLKS(EXT_CLKS), .AW_W(AW_W), .CNT_W(CNT_W)
    ) len_i (
        .ext_i(r_q.ext), .wr_i(r_q.wr), .auto_wait_i(r_q.autow),
        .as_len_o(as_len), .gap_len_o(gap_len),
        .ds_len_o(ds_len), .rec_len_o(rec_len)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.st    = ST_ADDR;
                    r_d.cnt   = '0;
                    r_d.addr  = req_addr_i;
                    r_d.wdata = req_wdata_i;
                    r_d.wr    = req_wr_i;
                    r_d.prog  = req_prog_i;
                    r_d.ext   = ext_mode_i;
                    r_d.autow = auto_wait_i;
                end
            end
            ST_ADDR: begin
                r_d.st  = ST_ASTB;
                r_d.cnt = as_len - CNT_W'(1);
            end
            ST_ASTB: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_FLOAT;
                    r_d.cnt = gap_len - CNT_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_FLOAT: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (r_q.wr) begin
                    r_d.st  = ST_DSET;
                    r_d.cnt = '0;
                end else begin
                    r_d.st  = ST_DSTB;
                    r_d.cnt = ds_len - CNT_W'(1);
                end
            end
            ST_DSET: begin
                r_d.st  = ST_DSTB;
                r_d.cnt = ds_len - CNT_W'(1);
            end
            ST_DSTB: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (wait_n_i) begin
                    r_d.st  = ST_REC;
                    r_d.cnt = rec_len - CNT_W'(1);
                    if (!r_q.wr) begin
                        r_d.rdata = ad_i;
                    end
                end
            end
            ST_REC: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    logic active, addr_ph, wdata_ph, dstb;

    assign active   = (r_q.st != ST_IDLE);
    assign addr_ph  = (r_q.st == ST_ADDR) || (r_q.st == ST_ASTB);
    assign wdata_ph = r_q.wr && ((r_q.st == ST_DSET) || (r_q.st == ST_DSTB)
                                 || (r_q.st == ST_REC));
    assign dstb     = (r_q.st == ST_DSTB);

    xbus_space_dec dec_i (
        .active_i(active), .prog_i(r_q.prog), .wr_i(r_q.wr), .dstb_i(dstb),
        .pm_n_o(pm_n_o), .dm_n_o(dm_n_o), .mr_n_o(mr_n_o), .mw_n_o(mw_n_o)
    );

    assign addr_hi_o = r_q.addr[ADDR_W-1:DATA_W];
    assign ad_o      = addr_ph ? r_q.addr[DATA_W-1:0]
                     : (wdata_ph ? r_q.wdata : '0);
    assign ad_oe_o   = addr_ph || wdata_ph;
    assign as_n_o    = (r_q.st != ST_ASTB);
    assign ds_n_o    = ~dstb;
    assign wr_o      = active && r_q.wr;
    assign rdata_o   = r_q.rdata;
    assign done_o    = r_q.done;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic as_n_o,
    input logic ds_n_o,
    input logic wr_o,
    input logic ad_oe_o,
    input logic mr_n_o,
    input logic mw_n_o,
    input logic pm_n_o,
    input logic dm_n_o,
    input logic done_o
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n_o && !ds_n_o)); // R4
    AST_AS_DRIVES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n_o |-> ad_oe_o); // R2
    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n_o && !wr_o) |-> !ad_oe_o); // R4
    AST_READ_FLOAT_BEFORE_DS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ds_n_o) && !wr_o) |-> $past(!ad_oe_o)); // R4
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n_o && wr_o) |-> ad_oe_o); // R5
    AST_RW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n_o && $past(!ds_n_o)) |-> $stable(wr_o)); // R3
    AST_STROBE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_n_o || !mw_n_o) |-> (!ds_n_o && (wr_o == !mr_n_o ? 1'b0 : 1'b1))); // R8
    AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~pm_n_o, ~dm_n_o}) <= 1); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12
endmodule

bind xbus_ctrl xbus_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .as_n_o(as_n_o), .ds_n_o(ds_n_o),
    .wr_o(wr_o), .ad_oe_o(ad_oe_o), .mr_n_o(mr_n_o), .mw_n_o(mw_n_o),
    .pm_n_o(pm_n_o), .dm_n_o(dm_n_o), .done_o(done_o)
);

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;
    localparam int AS_N = 1, GAP_N = 1, REC_N = 1, RD_N = 4, WR_N = 2, EXT_N = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_i = 1'b0, req_wr_i = 1'b0, req_prog_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [7:0]  req_wdata_i = '0;
    logic ext_mode_i = 1'b0;
    logic [1:0] auto_wait_i = '0;
    logic wait_n_i = 1'b1;
    logic [7:0] ad_i;
    logic [7:0] addr_hi_o, ad_o, rdata_o;
    logic ad_oe_o, as_n_o, ds_n_o, wr_o, mr_n_o, mw_n_o, pm_n_o, dm_n_o, done_o;

    always #2.5 clk = ~clk;

    xbus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_wr_i(req_wr_i),
        .req_prog_i(req_prog_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .ext_mode_i(ext_mode_i), .auto_wait_i(auto_wait_i), .wait_n_i(wait_n_i),
        .ad_i(ad_i), .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
        .as_n_o(as_n_o), .ds_n_o(ds_n_o), .wr_o(wr_o), .mr_n_o(mr_n_o),
        .mw_n_o(mw_n_o), .pm_n_o(pm_n_o), .dm_n_o(dm_n_o), .rdata_o(rdata_o),
        .done_o(done_o)
    );

    typedef struct {
        bit we; bit prog;
        logic [15:0] addr; logic [7:0] wd;
        int dsb; int pw; int as_len; int gap; int ds; int lat;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // memory model: data depends on the captured address
    logic [7:0] mem_lo = '0;
    assign ad_i = mem_lo ^ addr_hi_o ^ 8'hA5;

    // monitor
    bit in_tx = 0, prev_done = 0;
    int lat, as_cnt, gap_cnt, ds_cnt, ph;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                chk(!prev_done, "R12 done longer than one clock", 1, 0);
                if (!in_tx || q.size() == 0) begin
                    chk(1'b0, "R12 done without request", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    lat++;
                    chk(lat == e.lat, "R11 latency", lat, e.lat);
                    chk(as_cnt == e.as_len, "R2 as width", as_cnt, e.as_len);
                    chk(gap_cnt == e.gap, "R4 gap", gap_cnt, e.gap);
                    chk(ds_cnt == e.ds, "R6 R9 R10 ds width", ds_cnt, e.ds);
                    if (!e.we)
                        chk(rdata_o == (e.addr[7:0] ^ e.addr[15:8] ^ 8'hA5),
                            "R7 read data", rdata_o,
                            e.addr[7:0] ^ e.addr[15:8] ^ 8'hA5);
                end
                in_tx = 0;
                wait_n_i = 1'b1;
            end else if (!in_tx) begin
                if (!as_n_o || !ds_n_o)
                    chk(1'b0, "R12 strobe without accepted request", 0, 1);
                if (req_i && q.size() != 0) begin
                    in_tx = 1; lat = 0; as_cnt = 0; gap_cnt = 0; ds_cnt = 0; ph = 0;
                    wait_n_i = (q[0].pw > 0) ? 1'b0 : 1'b1;
                end
            end else begin
                exp_t e;
                e = q[0];
                lat++;
                chk(wr_o == e.we, "R3 wr level", wr_o, e.we);
                chk(pm_n_o == !e.prog && dm_n_o == e.prog, "R8 space select",
                    {pm_n_o, dm_n_o}, {!e.prog, e.prog});
                if (!as_n_o) begin
                    as_cnt++; ph = 1;
                    mem_lo = ad_o;
                    chk(ad_oe_o && ad_o == e.addr[7:0] && addr_hi_o == e.addr[15:8],
                        "R2 address on bus", {ad_oe_o, addr_hi_o, ad_o}, {1'b1, e.addr});
                end else if (!ds_n_o) begin
                    ds_cnt++; ph = 2;
                    chk(mr_n_o == e.we && mw_n_o == !e.we, "R8 rd/wr strobe",
                        {mr_n_o, mw_n_o}, {e.we, !e.we});
                    if (e.we)
                        chk(ad_oe_o && ad_o == e.wd, "R5 write data in strobe",
                            {ad_oe_o, ad_o}, {1'b1, e.wd});
                    else
                        chk(!ad_oe_o, "R4 read float in strobe", ad_oe_o, 0);
                    wait_n_i = (ds_cnt < e.dsb + e.pw) ? 1'b0 : 1'b1;
                end else if (ph == 1) begin
                    gap_cnt++;
                    if (!e.we) chk(!ad_oe_o, "R4 read float in gap", ad_oe_o, 0);
                end else if (ph == 2) begin
                    ph = 3;
                    if (e.we)
                        chk(ad_oe_o && ad_o == e.wd, "R5 write data hold",
                            {ad_oe_o, ad_o}, {1'b1, e.wd});
                    else
                        chk(!ad_oe_o, "R4 read float in recovery", ad_oe_o, 0);
                end
            end
            prev_done = done_o;
        end
    end

    task automatic run(input bit we, input bit prog, input bit ext,
                       input logic [15:0] a, input logic [7:0] wd,
                       input int aw, input int pw, input bit poke);
        exp_t e;
        int n;
        e.we = we; e.prog = prog; e.addr = a; e.wd = wd; e.pw = pw;
        e.as_len = AS_N + (ext ? EXT_N : 0);
        e.gap    = GAP_N + (ext ? EXT_N : 0) + (we ? 1 : 0);
        e.dsb    = (we ? WR_N : RD_N) + aw + (ext ? EXT_N : 0);
        e.ds     = e.dsb + pw;
        e.lat    = 1 + e.as_len + e.gap + e.ds + REC_N + (ext ? EXT_N : 0) + 1;
        q.push_back(e);
        @(posedge clk); #1;
        req_i = 1'b1; req_wr_i = we; req_prog_i = prog; req_addr_i = a;
        req_wdata_i = wd; ext_mode_i = ext; auto_wait_i = 2'(aw);
        @(posedge clk); #1;
        req_i = 1'b0;
        n = 0;
        while (!done_o) begin
            n++;
            if (poke && n == 3) begin   // R12: request while busy
                req_i = 1'b1; req_addr_i = ~a; req_wr_i = ~we;
                ext_mode_i = ~ext; auto_wait_i = 2'd0;
            end
            if (poke && n == 4) req_i = 1'b0;
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #2000000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(as_n_o && ds_n_o && mr_n_o && mw_n_o && pm_n_o && dm_n_o,
            "R1 strobes idle", {as_n_o, ds_n_o, mr_n_o, mw_n_o, pm_n_o, dm_n_o}, 6'h3F);
        chk(!ad_oe_o && !wr_o && !done_o, "R1 enables idle",
            {ad_oe_o, wr_o, done_o}, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        run(0, 0, 0, 16'h3C81, 8'h00, 0, 0, 0); // R6 R7 normal read
        run(1, 0, 0, 16'h4410, 8'h9E, 0, 0, 0); // R5 R6 normal write
        run(0, 1, 0, 16'h8001, 8'h00, 0, 0, 0); // R8 program read
        run(1, 1, 1, 16'h7F20, 8'h5B, 0, 0, 0); // R11 extended write
        run(0, 0, 1, 16'h12EF, 8'h00, 2, 0, 0); // R9 R11 auto waits
        run(1, 0, 0, 16'hA0A0, 8'hC3, 3, 0, 0); // R9 max auto waits
        run(0, 1, 0, 16'h5566, 8'h00, 1, 2, 0); // R10 wait pin after auto
        run(1, 0, 1, 16'h0F0F, 8'h77, 0, 3, 0); // R10 R11 wait pin write
        run(0, 0, 0, 16'h2468, 8'h00, 0, 0, 1); // R12 request while busy
        run(1, 1, 1, 16'hBEEF, 8'h01, 1, 1, 1); // R12 poke in extended write
        run(1, 0, 0, 16'hFFFF, 8'hFF, 0, 0, 0); // R2 top address
        run(0, 1, 1, 16'h0000, 8'h00, 3, 1, 0); // R2 R9 zero address
        @(negedge clk);
        chk(q.size() == 0, "R12 outstanding transactions", q.size(), 0);
        chk(as_n_o && ds_n_o && !ad_oe_o && pm_n_o && dm_n_o, "R1 idle after traffic",
            {as_n_o, ds_n_o, ad_oe_o, pm_n_o, dm_n_o}, 5'b11011);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule